// File: doc/BRIEF.md
# Swept-Frequency Phase Generator

This block produces the phase word for a direct digital synthesizer that can hold a fixed tone, ramp between frequencies, or sweep linearly. It is built from two 48-bit accumulators in series. The first is a frequency-offset accumulator. It advances by a programmed delta word only when a programmable ramp-rate divider emits a tick. The offset is added to a base tuning word taken from one of two frequency registers. The result is the instantaneous frequency word. The second accumulator integrates that word into phase on every system clock.

The phase accumulator keeps the full 48-bit phase. It also offers a truncated copy of the top bits, which a later sine lookup can use. A change of mode or of the base-register select restarts the sweep from the base frequency. Reset is synchronous and active high. The surrounding system holds it for at least ten clocks, and every register returns to its default.

Top module: `dds_sweep_core`

## Requirements
- R1: While `rst` is high, `phase_word`, `phase_trunc` and `freq_word` are zero on the clock edge after reset is sampled.
- R2: In tone mode, `freq_word` equals `f1_word` when `tone_sel` is 0 and `f2_word` when it is 1. It takes this value one clock after the inputs are sampled.
- R3: On every clock, `phase_word` becomes its previous value plus the previous `freq_word`, modulo 2^48.
- R4: `phase_trunc` always equals bits [47:34] of `phase_word`.
- R5: In a sweep mode, the ramp divider loaded with value N emits one tick every N+1 clocks. The first tick comes N+1 clocks after the edge that starts the sweep, so N = 0 gives a tick on every clock.
- R6: In a sweep mode, each ramp tick adds `delta_word` to the frequency offset, modulo 2^48. `freq_word` then shows base + offset, wrapping modulo 2^48.
- R7: In ramped-FSK mode, `tone_sel` chooses F1 (0) or F2 (1) as the base. In chirp mode, the base is always F1, whatever `tone_sel` is.
- R8: `mode_sel` encodings: 2'b00 is tone, 2'b01 is ramped FSK, 2'b10 is chirp, and 2'b11 also acts as tone.
- R9: Any change of `mode_sel` or `tone_sel` clears the frequency offset to zero and reloads the ramp divider on that edge.
- R10: In tone mode, `delta_word` and `ramp_div` have no effect on `freq_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode (see R8) |
| tone_sel | input | 1 | Base frequency register select |
| f1_word | input | 48 | First base tuning word |
| f2_word | input | 48 | Second base tuning word |
| delta_word | input | 48 | Frequency increment per ramp tick |
| ramp_div | input | 20 | Ramp divider reload value |
| phase_word | output | 48 | Full phase accumulator |
| phase_trunc | output | 14 | Top phase bits for sine lookup |
| freq_word | output | 48 | Instantaneous frequency word |

## Verification
The bench builds the block with its default parameters: 48-bit accumulators, a 20-bit divider and a 14-bit truncated phase. Divider values stay small, from 0 to a few units, so ramp ticks and several offset steps happen within tens of cycles. Tuning and delta words near 2^48 make both the frequency offset and the phase wrap within a few clocks. This exercises the modulo behaviour at full width without long runs.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;

  typedef enum logic [1:0] {
    MODE_TONE     = 2'b00,
    MODE_FSK      = 2'b01,
    MODE_CHIRP    = 2'b10,
    MODE_TONE_ALT = 2'b11
  } sweep_mode_e;

  function automatic logic mode_is_sweep(input logic [1:0] m);
    return (m == MODE_FSK) || (m == MODE_CHIRP);
  endfunction

  function automatic logic mode_is_chirp(input logic [1:0] m);
    return m == MODE_CHIRP;
  endfunction

endpackage

// File: rtl/ramp_tick_gen.sv
module ramp_tick_gen #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] count_q;
  logic             at_zero;

  assign at_zero = (count_q == '0);
  assign tick    = enable && !restart && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= div_val;
    end else if (!enable || restart || at_zero) begin
      count_q <= div_val;
    end else begin
      count_q <= count_q - 1'b1;
    end
  end

endmodule

// File: rtl/freq_ramp_acc.sv
module freq_ramp_acc #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [ACC_W-1:0] delta,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_d
);

  always_comb begin
    if (clear) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = acc_q + delta;
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/phase_integrator.sv
module phase_integrator #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq_in,
  output logic [ACC_W-1:0] phase_q,
  output logic [OUT_W-1:0] phase_top
);

  localparam int LSB = ACC_W - OUT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + freq_in;
    end
  end

  generate
    if (OUT_W >= ACC_W) begin : g_full
      assign phase_top = OUT_W'(phase_q);
    end else begin : g_trunc
      assign phase_top = phase_q[ACC_W-1:LSB];
    end
  endgenerate

endmodule

// File: rtl/dds_sweep_core.sv
module dds_sweep_core
  import dds_sweep_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int DIV_W = 20,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             tone_sel,
  input  logic [ACC_W-1:0] f1_word,
  input  logic [ACC_W-1:0] f2_word,
  input  logic [ACC_W-1:0] delta_word,
  input  logic [DIV_W-1:0] ramp_div,
  output logic [ACC_W-1:0] phase_word,
  output logic [OUT_W-1:0] phase_trunc,
  output logic [ACC_W-1:0] freq_word
);

  logic [1:0]       mode_prev_q;
  logic             sel_prev_q;
  logic             restart;
  logic             sweep_on;
  logic             ramp_tick;
  logic [ACC_W-1:0] facc_q;
  logic [ACC_W-1:0] facc_d;
  logic [ACC_W-1:0] base_word;
  logic [ACC_W-1:0] freq_q;

  assign sweep_on = mode_is_sweep(mode_sel);
  assign restart  = (mode_sel != mode_prev_q) || (tone_sel != sel_prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prev_q <= MODE_TONE;
      sel_prev_q  <= 1'b0;
    end else begin
      mode_prev_q <= mode_sel;
      sel_prev_q  <= tone_sel;
    end
  end

  ramp_tick_gen #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .enable  (sweep_on),
    .restart (restart),
    .div_val (ramp_div),
    .tick    (ramp_tick)
  );

  freq_ramp_acc #(.ACC_W(ACC_W)) u_facc (
    .clk   (clk),
    .rst   (rst),
    .clear (restart || !sweep_on),
    .step  (ramp_tick),
    .delta (delta_word),
    .acc_q (facc_q),
    .acc_d (facc_d)
  );

  always_comb begin
    if (mode_is_chirp(mode_sel)) begin
      base_word = f1_word;
    end else begin
      base_word = tone_sel ? f2_word : f1_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else begin
      freq_q <= base_word + facc_d;
    end
  end

  assign freq_word = freq_q;

  phase_integrator #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .freq_in   (freq_q),
    .phase_q   (phase_word),
    .phase_top (phase_trunc)
  );

endmodule

// File: rtl/dds_sweep_checker.sv
module dds_sweep_checker #(
  parameter int ACC_W = 48,
  parameter int DIV_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic             tone_sel,
  input logic [ACC_W-1:0] f1_word,
  input logic [ACC_W-1:0] f2_word,
  input logic [DIV_W-1:0] ramp_div,
  input logic [ACC_W-1:0] phase_word,
  input logic [ACC_W-1:0] freq_word,
  input logic             tick,
  input logic             restart,
  input logic             sweep,
  input logic [ACC_W-1:0] facc
);

  // R3
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_word == ACC_W'($past(phase_word) + $past(freq_word)));

  // R2, R10
  p_tone_freq_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sweep)) |-> freq_word == ($past(tone_sel) ? $past(f2_word) : $past(f1_word)));

  // R9
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restart)) |-> facc == '0);

  // R6
  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sweep) && !$past(restart) && !$past(tick)) |-> facc == $past(facc));

  // R5
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick) && $past(ramp_div) != '0 && $stable(ramp_div)) |-> !tick);

endmodule

bind dds_sweep_core dds_sweep_checker #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .tone_sel   (tone_sel),
  .f1_word    (f1_word),
  .f2_word    (f2_word),
  .ramp_div   (ramp_div),
  .phase_word (phase_word),
  .freq_word  (freq_word),
  .tick       (ramp_tick),
  .restart    (restart),
  .sweep      (sweep_on),
  .facc       (facc_q)
);

// File: tb/tb_dds_sweep_core.sv
`timescale 1ns/1ps
module tb_dds_sweep_core;

  localparam int AW = 48;
  localparam int DW = 20;
  localparam int OW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'b00;
  logic          tone_sel = 1'b0;
  logic [AW-1:0] f1_word = '0;
  logic [AW-1:0] f2_word = '0;
  logic [AW-1:0] delta_word = '0;
  logic [DW-1:0] ramp_div = '0;
  logic [AW-1:0] phase_word;
  logic [OW-1:0] phase_trunc;
  logic [AW-1:0] freq_word;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dds_sweep_core dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .tone_sel(tone_sel),
    .f1_word(f1_word), .f2_word(f2_word), .delta_word(delta_word),
    .ramp_div(ramp_div), .phase_word(phase_word), .phase_trunc(phase_trunc),
    .freq_word(freq_word)
  );

  // Spec-level model state
  logic [AW-1:0] m_off, m_fw, m_ph;
  logic [DW-1:0] m_cnt;
  logic [1:0]    m_pm;
  logic          m_ps;

  typedef struct packed {
    logic [1:0]    mode;
    logic          sel;
    logic [AW-1:0] f1;
    logic [AW-1:0] f2;
    logic [AW-1:0] delta;
    logic [DW-1:0] div;
    logic [15:0]   ncyc;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b00, 1'b0, 48'h0000_1234_5678, 48'h0000_0000_0100, 48'h1, 20'd3, 16'd20},
    '{2'b00, 1'b1, 48'h0000_1234_5678, 48'h0800_0000_0000, 48'h1, 20'd3, 16'd21},
    '{2'b01, 1'b0, 48'h0000_0100_0000, 48'h0000_0200_0000, 48'h0000_0000_1000, 20'd2, 16'd30},
    '{2'b01, 1'b1, 48'h0000_0100_0000, 48'h0000_0200_0000, 48'h0000_0000_1000, 20'd1, 16'd25},
    '{2'b10, 1'b1, 48'h0000_0300_0000, 48'h7777_0000_0000, 48'h0000_0010_0000, 20'd4, 16'd40},
    '{2'b10, 1'b0, 48'hFFFF_FFFF_0000, 48'h0, 48'h0000_0000_8000, 20'd0, 16'd12},
    '{2'b11, 1'b1, 48'h0000_0000_0007, 48'h0123_4567_89AB, 48'h5, 20'd0, 16'd17}
  };

  function automatic logic is_sweep(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic step();
    logic          rs, tk;
    logic [AW-1:0] off_n, base;
    logic [DW-1:0] cnt_n;
    if (rst) begin
      off_n = '0; cnt_n = ramp_div;
      @(posedge clk);
      m_off = '0; m_fw = '0; m_ph = '0; m_cnt = cnt_n; m_pm = 2'b00; m_ps = 1'b0;
    end else begin
      rs = (mode_sel != m_pm) || (tone_sel != m_ps);
      tk = is_sweep(mode_sel) && !rs && (m_cnt == '0);
      if (rs || !is_sweep(mode_sel)) off_n = '0;
      else if (tk) off_n = m_off + delta_word;
      else off_n = m_off;
      cnt_n = (rs || !is_sweep(mode_sel) || m_cnt == '0) ? ramp_div : m_cnt - 1'b1;
      base = (mode_sel == 2'b10) ? f1_word : (tone_sel ? f2_word : f1_word);
      @(posedge clk);
      m_ph = m_ph + m_fw;
      m_fw = base + off_n;
      m_off = off_n; m_cnt = cnt_n; m_pm = mode_sel; m_ps = tone_sel;
    end
    #2;
  endtask

  task automatic check48(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 10; i++) step();
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'b01: return "R7";
      2'b10: return "R6";
      2'b11: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] f, d, base;
    do_reset();
    // R1 reset state
    check48("R1", "phase_word in reset", phase_word, '0);
    check48("R1", "freq_word in reset", freq_word, '0);
    check48("R1", "phase_trunc in reset", {34'd0, phase_trunc}, '0);

    // Vector table walk
    foreach (VECS[k]) begin
      mode_sel = VECS[k].mode; tone_sel = VECS[k].sel;
      f1_word = VECS[k].f1; f2_word = VECS[k].f2;
      delta_word = VECS[k].delta; ramp_div = VECS[k].div;
      do_reset();
      run(int'(VECS[k].ncyc));
      check48(tag(VECS[k].mode), "vector freq_word", freq_word, m_fw);
      check48("R3", "vector phase_word", phase_word, m_ph);
      check48("R4", "vector phase_trunc", {34'd0, phase_trunc}, {34'd0, phase_word[47:34]});
    end

    // R3/R4 single tone closed form with wrap: phase = (n-1)*f
    f = 48'hF000_0000_0001;
    mode_sel = 2'b00; tone_sel = 1'b0; f1_word = f; delta_word = '0; ramp_div = '0;
    do_reset();
    run(6);
    check48("R3", "tone phase wrap", phase_word, f * 48'd5);
    base = f * 48'd5;
    check48("R4", "tone phase_trunc", {34'd0, phase_trunc}, {34'd0, base[47:34]});

    // R5 divider period: div=4, offset = floor(N/5)*d with N = steps-1
    d = 48'h100; mode_sel = 2'b10; tone_sel = 1'b0; f1_word = 48'h1000;
    delta_word = d; ramp_div = 20'd4;
    do_reset();
    run(15);
    check48("R5", "offset after 14 edges", freq_word, 48'h1000 + 2 * d);
    run(1);
    check48("R5", "offset after 15 edges", freq_word, 48'h1000 + 3 * d);

    // R6 delta wrap with div=0: f1 + (N)*d, N = steps-1
    d = 48'h8000_0000_0000; f1_word = 48'h10; delta_word = d; ramp_div = '0;
    do_reset();
    run(4);
    check48("R6", "offset wraps modulo 2^48", freq_word, 48'h10 + 3 * d);

    // R7 chirp ignores tone_sel for base
    mode_sel = 2'b10; tone_sel = 1'b1; f1_word = 48'h2222; f2_word = 48'h9999;
    delta_word = '0; ramp_div = 20'd2;
    do_reset();
    run(3);
    check48("R7", "chirp base is F1", freq_word, 48'h2222);

    // R9 select change mid-ramp clears offset
    mode_sel = 2'b01; tone_sel = 1'b0; f1_word = 48'h1000; f2_word = 48'h5000;
    delta_word = 48'h10; ramp_div = '0;
    do_reset();
    run(8);
    check48("R9", "ramp before select change", freq_word, 48'h1000 + 7 * 48'h10);
    tone_sel = 1'b1;
    run(1);
    check48("R9", "offset cleared on select change", freq_word, 48'h5000);
    mode_sel = 2'b10;
    run(1);
    check48("R9", "offset cleared on mode change", freq_word, 48'h1000);

    // R10 tone mode ignores delta and divider
    mode_sel = 2'b00; tone_sel = 1'b0; f1_word = 48'h3333; delta_word = 48'h1;
    ramp_div = '0;
    do_reset();
    run(3);
    delta_word = 48'hFFFF; ramp_div = 20'd1;
    run(5);
    check48("R10", "tone freq unaffected", freq_word, 48'h3333);

    // R8 mode 11 acts as tone
    mode_sel = 2'b11; tone_sel = 1'b1; f2_word = 48'h4444; delta_word = 48'h7;
    run(9);
    check48("R8", "mode 11 holds F2", freq_word, 48'h4444);

    // R1 reset mid-run
    rst = 1'b1;
    step();
    check48("R1", "phase cleared by reset", phase_word, '0);
    check48("R1", "freq cleared by reset", freq_word, '0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule